// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies even parity for a multiplexed 32-bit address/data bus together with its 4-bit command/byte-enable lanes. The device around it can be either the initiator or the target of a transfer. Every clock it is told which phase is on the bus (address or data), the transfer direction, and which role the device currently has. From these it decides whether it is the party that drives the parity line or the party that checks it.

When it owns parity, it drives the parity bit and an output enable one clock after the bus values that bit covers. When it checks, it registers the expected parity of the bus and compares that value with the parity line one clock later. A failed address check raises the active-low system-error line. A failed data check raises the active-low parity-error line. Either line goes low for a single clock, two clocks after the phase that failed.

Three sticky status bits record the errors, and software clears them by writing ones. An error seen while the device is initiator, whether detected locally on read data or reported back by the target, makes the block wait for the end of the current burst. It then raises a halt request, which stays up until software clears the initiator error bit.

Top module: `pci_parity_guard`

## Requirements
- R1: Parity is even over all 36 bits: when `par_oe_o` is 1, the number of ones in `ad_i`, `cbe_n_i` and `par_o` together, counting the bus values of the previous clock, is even.
- R2: `par_oe_o` is 1 in the clock after a cycle in which the block owns parity, and 0 otherwise. It owns parity as initiator (`master_i`=1) in an address phase or a write (`write_i`=1) data phase, and as target in a read data phase.
- R3: Parity is checked only in three cases: as target on every address phase, as initiator on read data phases, and as target on write data phases. A mismatch in any other cycle raises no error line and sets no status bit.
- R4: A data phase is checked only if it completes, that is if `irdy_n_i` and `trdy_n_i` are both 0 in that cycle. A data phase with either ready line high is ignored.
- R5: A data parity mismatch drives `perr_n_o` low for exactly one clock, in the second clock after the data phase.
- R6: An address parity mismatch drives `serr_n_o` low for exactly one clock, in the second clock after the address phase.
- R7: `sts_o` bit 0 records data parity errors, bit 1 records address parity errors and bit 2 records initiator-side errors. Each bit is sticky and is cleared by writing 1 to the same bit of `sts_clr_i`. If a bit is set and cleared in the same clock, the set wins.
- R8: An initiator-side error sets bit 2 of `sts_o`. This happens when a data parity mismatch is detected on an initiator read, or when `perr_n_i` is 0 while the block is initiator of a write.
- R9: While bit 2 of `sts_o` is set, `halt_o` rises in the clock after `burst_end_i` is 1 and then stays at 1. `halt_o` falls when bit 2 is cleared.
- R10: After reset `par_oe_o`=0, `perr_n_o`=1, `serr_n_o`=1, `sts_o`=0 and `halt_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Sampled address/data bus |
| cbe_n_i | input | 4 | Sampled command/byte-enable lanes |
| par_i | input | 1 | Sampled parity line |
| addr_ph_i | input | 1 | Address phase in this cycle |
| data_ph_i | input | 1 | Data phase in this cycle |
| write_i | input | 1 | 1 = write transfer, 0 = read |
| master_i | input | 1 | 1 = device is initiator, 0 = target |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| perr_n_i | input | 1 | Parity error reported by another agent, active low |
| burst_end_i | input | 1 | Current burst finishes in this cycle |
| sts_clr_i | input | 3 | Write-one-to-clear strobes for the status bits |
| par_o | output | 1 | Generated parity |
| par_oe_o | output | 1 | Drive enable for par_o |
| perr_n_o | output | 1 | Data parity error, active low |
| serr_n_o | output | 1 | System error for address parity, active low |
| sts_o | output | 3 | Sticky error status |
| halt_o | output | 1 | Halt request after an initiator-side error |

## Verification
Two things can hit the same status bit in the same clock: the recording of a freshly detected error, and the software clear of that bit. The bench forces this overlap with a directed sequence. It completes a target write data phase, and in the clock where the wrong parity arrives it also writes one to the data-error clear bit. It then expects the bit to stay set, and to drop only after a second clear issued on its own. Random traffic with injected parity flips and random clears also produces this overlap, along with initiator reports landing on top of a clear. Every such case is judged against a cycle model that applies the clear first and the set after it.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

   localparam int STS_W        = 3;
   localparam int STS_DATA_ERR = 0;
   localparam int STS_ADDR_ERR = 1;
   localparam int STS_MST_ERR  = 2;

   typedef struct packed {
      logic addr;
      logic data;
      logic wr;
      logic mst;
   } phase_t;

endpackage

// File: rtl/pci_par_tree.sv
module pci_par_tree #(
   parameter int W    = 36,
   parameter int LANE = 8,
   parameter bit TREE = 1'b1
) (
   input  logic [W-1:0] vec_i,
   output logic         par_o
);

   generate
      if (LANE < 1) begin : g_bad_lane
         $error("pci_par_tree: LANE must be at least 1");
      end

      if (TREE) begin : g_tree
         localparam int NL = (W + LANE - 1) / LANE;
         logic [NL-1:0] lane_par;
         for (genvar i = 0; i < NL; i++) begin : g_lane
            localparam int LO = i * LANE;
            localparam int HI = (LO + LANE > W) ? W - 1 : LO + LANE - 1;
            assign lane_par[i] = ^vec_i[HI:LO];
         end
         assign par_o = ^lane_par;
      end else begin : g_flat
         assign par_o = ^vec_i;
      end
   endgenerate

endmodule

// File: rtl/pci_par_gen.sv
module pci_par_gen
   import pci_par_pkg::*;
#(
   parameter int W = 36
) (
   input  logic         clk,
   input  logic         rst_n,
   input  phase_t       ph_i,
   input  logic         bus_par_i,
   input  logic [W-1:0] bus_i,
   output logic         par_o,
   output logic         par_oe_o
);

   logic own;
   logic par_q;
   logic oe_q;

   always_comb begin
      if (ph_i.mst)
         own = ph_i.addr | (ph_i.data & ph_i.wr);
      else
         own = ph_i.data & ~ph_i.wr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         par_q <= bus_par_i;
         oe_q  <= own;
      end
   end

   assign par_o    = par_q;
   assign par_oe_o = oe_q;

   // R1
   even_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
      par_oe_o |-> ((^{$past(bus_i), par_o}) == 1'b0));

   // R2
   oe_needs_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      par_oe_o |-> $past(ph_i.addr | ph_i.data));

endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk
   import pci_par_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  phase_t ph_i,
   input  logic   irdy_n_i,
   input  logic   trdy_n_i,
   input  logic   bus_par_i,
   input  logic   par_i,
   output logic   data_err_o,
   output logic   addr_err_o,
   output logic   mst_data_err_o,
   output logic   perr_n_o,
   output logic   serr_n_o
);

   logic xfer;
   logic chk_addr_d, chk_data_d;
   logic chk_addr_q, chk_data_q, chk_mst_q, exp_q;
   logic mism;
   logic perr_q, serr_q;

   assign xfer       = ph_i.data & ~irdy_n_i & ~trdy_n_i;
   assign chk_addr_d = ph_i.addr & ~ph_i.mst;
   assign chk_data_d = xfer & (ph_i.mst ? ~ph_i.wr : ph_i.wr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_addr_q <= 1'b0;
         chk_data_q <= 1'b0;
         chk_mst_q  <= 1'b0;
         exp_q      <= 1'b0;
      end else begin
         chk_addr_q <= chk_addr_d;
         chk_data_q <= chk_data_d;
         chk_mst_q  <= ph_i.mst;
         exp_q      <= bus_par_i;
      end
   end

   assign mism           = par_i ^ exp_q;
   assign data_err_o     = chk_data_q & mism;
   assign addr_err_o     = chk_addr_q & mism;
   assign mst_data_err_o = data_err_o & chk_mst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perr_q <= 1'b0;
         serr_q <= 1'b0;
      end else begin
         perr_q <= data_err_o;
         serr_q <= addr_err_o;
      end
   end

   assign perr_n_o = ~perr_q;
   assign serr_n_o = ~serr_q;

   // R5
   perr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_n_o |-> $past(chk_data_q));

   // R6
   serr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n_o |-> $past(chk_addr_q));

endmodule

// File: rtl/pci_par_sts.sv
module pci_par_sts
   import pci_par_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_err_i,
   input  logic             addr_err_i,
   input  logic             mst_err_i,
   input  logic             burst_end_i,
   input  logic [STS_W-1:0] clr_i,
   output logic [STS_W-1:0] sts_o,
   output logic             halt_o
);

   logic [STS_W-1:0] set_v;
   logic [STS_W-1:0] sts_q, sts_d;
   logic             halt_q, halt_d;

   always_comb begin
      set_v               = '0;
      set_v[STS_DATA_ERR] = data_err_i;
      set_v[STS_ADDR_ERR] = addr_err_i;
      set_v[STS_MST_ERR]  = mst_err_i;
      sts_d               = (sts_q & ~clr_i) | set_v;
      halt_d              = sts_d[STS_MST_ERR] ? (halt_q | burst_end_i) : 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q  <= '0;
         halt_q <= 1'b0;
      end else begin
         sts_q  <= sts_d;
         halt_q <= halt_d;
      end
   end

   assign sts_o  = sts_q;
   assign halt_o = halt_q;

   // R7
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(sts_q) & ~$past(clr_i)) & ~sts_q) == '0));

   // R9
   halt_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |-> sts_o[STS_MST_ERR]);

   // R9
   halt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_o) |-> $past(burst_end_i));

endmodule

// File: rtl/pci_parity_guard.sv
module pci_parity_guard
   import pci_par_pkg::*;
#(
   parameter int AD_W     = 32,
   parameter int CBE_W    = 4,
   parameter bit TREE_XOR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AD_W-1:0]  ad_i,
   input  logic [CBE_W-1:0] cbe_n_i,
   input  logic             par_i,
   input  logic             addr_ph_i,
   input  logic             data_ph_i,
   input  logic             write_i,
   input  logic             master_i,
   input  logic             irdy_n_i,
   input  logic             trdy_n_i,
   input  logic             perr_n_i,
   input  logic             burst_end_i,
   input  logic [STS_W-1:0] sts_clr_i,
   output logic             par_o,
   output logic             par_oe_o,
   output logic             perr_n_o,
   output logic             serr_n_o,
   output logic [STS_W-1:0] sts_o,
   output logic             halt_o
);

   localparam int BUS_W = AD_W + CBE_W;

   generate
      if (AD_W % 8 != 0) begin : g_bad_ad
         $error("pci_parity_guard: AD_W must be a multiple of 8");
      end
      if (CBE_W * 8 != AD_W) begin : g_bad_cbe
         $error("pci_parity_guard: CBE_W must be AD_W/8");
      end
   endgenerate

   phase_t           ph;
   logic [BUS_W-1:0] bus;
   logic             bus_par;
   logic             data_err, addr_err, mst_data_err, mst_report;

   assign ph.addr = addr_ph_i;
   assign ph.data = data_ph_i;
   assign ph.wr   = write_i;
   assign ph.mst  = master_i;
   assign bus     = {cbe_n_i, ad_i};

   pci_par_tree #(.W(BUS_W), .LANE(8), .TREE(TREE_XOR)) u_tree (
      .vec_i (bus),
      .par_o (bus_par)
   );

   pci_par_gen #(.W(BUS_W)) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .ph_i      (ph),
      .bus_par_i (bus_par),
      .bus_i     (bus),
      .par_o     (par_o),
      .par_oe_o  (par_oe_o)
   );

   pci_par_chk u_chk (
      .clk            (clk),
      .rst_n          (rst_n),
      .ph_i           (ph),
      .irdy_n_i       (irdy_n_i),
      .trdy_n_i       (trdy_n_i),
      .bus_par_i      (bus_par),
      .par_i          (par_i),
      .data_err_o     (data_err),
      .addr_err_o     (addr_err),
      .mst_data_err_o (mst_data_err),
      .perr_n_o       (perr_n_o),
      .serr_n_o       (serr_n_o)
   );

   assign mst_report = master_i & write_i & ~perr_n_i;

   pci_par_sts u_sts (
      .clk         (clk),
      .rst_n       (rst_n),
      .data_err_i  (data_err),
      .addr_err_i  (addr_err),
      .mst_err_i   (mst_data_err | mst_report),
      .burst_end_i (burst_end_i),
      .clr_i       (sts_clr_i),
      .sts_o       (sts_o),
      .halt_o      (halt_o)
   );

   // R8
   report_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (master_i && write_i && !perr_n_i) |=> sts_o[STS_MST_ERR]);

   // R5
   perr_flags_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_n_o |-> sts_o[STS_DATA_ERR]);

endmodule

// File: tb/pci_parity_guard_tb.sv
`timescale 1ns/1ps
module pci_parity_guard_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ad = '0;
   logic [3:0]  cbe_n = '0;
   logic        par_in = 1'b0;
   logic        addr_ph = 1'b0, data_ph = 1'b0, wr = 1'b0, mst = 1'b0;
   logic        irdy_n = 1'b1, trdy_n = 1'b1, perr_in_n = 1'b1, burst = 1'b0;
   logic [2:0]  clr = '0;
   logic        par_o, par_oe_o, perr_n_o, serr_n_o, halt_o;
   logic [2:0]  sts_o;

   pci_parity_guard u_dut (
      .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe_n), .par_i(par_in),
      .addr_ph_i(addr_ph), .data_ph_i(data_ph), .write_i(wr), .master_i(mst),
      .irdy_n_i(irdy_n), .trdy_n_i(trdy_n), .perr_n_i(perr_in_n),
      .burst_end_i(burst), .sts_clr_i(clr), .par_o(par_o), .par_oe_o(par_oe_o),
      .perr_n_o(perr_n_o), .serr_n_o(serr_n_o), .sts_o(sts_o), .halt_o(halt_o)
   );

   always #2 clk = ~clk;

   int total = 0;
   int bad   = 0;

   // directed/random stimulus for next cycle
   logic [31:0] d_ad;
   logic [3:0]  d_cbe;
   logic d_addr, d_data, d_wr, d_mst, d_irdy, d_trdy, d_perr, d_burst, d_inj;
   logic [2:0]  d_clr;
   logic        last_bp = 1'b0;

   // model state
   logic m_oe = 0, m_par = 0, m_perr = 0, m_serr = 0, m_halt = 0;
   logic m_ck_addr = 0, m_ck_data = 0, m_ck_mst = 0, m_exp = 0;
   logic [2:0] m_sts = '0;

   function automatic logic bus_parity(input logic [31:0] a, input logic [3:0] c);
      return ^{c, a};
   endfunction

   function automatic logic owns(input logic a, input logic d, input logic w, input logic m);
      return m ? (a | (d & w)) : (d & ~w);
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      d_ad = '0; d_cbe = '0; d_addr = 0; d_data = 0; d_wr = 0; d_mst = 0;
      d_irdy = 1; d_trdy = 1; d_perr = 1; d_burst = 0; d_inj = 0; d_clr = '0;
   endtask

   task automatic update_model();
      logic mis, e_d, e_a, mset;
      logic [2:0] nsts;
      mis  = par_in ^ m_exp;
      e_d  = m_ck_data & mis;
      e_a  = m_ck_addr & mis;
      mset = (e_d & m_ck_mst) | (mst & wr & ~perr_in_n);
      nsts = (m_sts & ~clr) | {mset, e_a, e_d};
      m_halt = nsts[2] ? (m_halt | burst) : 1'b0;
      m_sts  = nsts;
      m_perr = e_d;
      m_serr = e_a;
      m_oe   = owns(addr_ph, data_ph, wr, mst);
      m_par  = bus_parity(ad, cbe_n);
      m_ck_addr = addr_ph & ~mst;
      m_ck_data = data_ph & ~irdy_n & ~trdy_n & (mst ? ~wr : wr);
      m_ck_mst  = mst;
      m_exp     = bus_parity(ad, cbe_n);
   endtask

   // called at a negedge: compare, drive, advance one clock, return at next negedge
   task automatic cyc();
      check(par_oe_o == m_oe, "R2 par_oe_o", par_oe_o, m_oe);
      if (m_oe) check(par_o == m_par, "R1 par_o", par_o, m_par);
      check(perr_n_o == ~m_perr, "R5 perr_n_o", perr_n_o, ~m_perr);
      check(serr_n_o == ~m_serr, "R6 serr_n_o", serr_n_o, ~m_serr);
      check(sts_o == m_sts, "R7 sts_o", sts_o, m_sts);
      check(halt_o == m_halt, "R9 halt_o", halt_o, m_halt);
      par_in = last_bp ^ d_inj;
      ad = d_ad; cbe_n = d_cbe; addr_ph = d_addr; data_ph = d_data; wr = d_wr;
      mst = d_mst; irdy_n = d_irdy; trdy_n = d_trdy; perr_in_n = d_perr;
      burst = d_burst; clr = d_clr;
      last_bp = bus_parity(d_ad, d_cbe);
      @(posedge clk);
      #1 update_model();
      @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      idle();
      repeat (3) @(negedge clk);
      // R10 reset state
      check(par_oe_o == 0 && perr_n_o == 1 && serr_n_o == 1 && sts_o == 0 && halt_o == 0,
            "R10 reset outputs", {par_oe_o, perr_n_o, serr_n_o, sts_o, halt_o}, 7'b0110000);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: incomplete target write data phase with bad parity is ignored
      idle(); d_data = 1; d_wr = 1; d_irdy = 1; d_trdy = 0; d_ad = 32'hA5A5_0001; cyc();
      idle(); d_inj = 1; cyc();
      idle(); cyc();
      check(perr_n_o == 1 && sts_o[0] == 0, "R4 no check without completion", perr_n_o, 1);

      // R5: completed target write data phase, bad parity -> one-clock perr two clocks later
      idle(); d_data = 1; d_wr = 1; d_irdy = 0; d_trdy = 0; d_ad = 32'h1234_5678; d_cbe = 4'h3; cyc();
      idle(); d_inj = 1; cyc();
      check(perr_n_o == 0, "R5 perr low at phase+2", perr_n_o, 0);
      idle(); cyc();
      check(perr_n_o == 1, "R5 perr single clock", perr_n_o, 1);

      // R3: initiator write data with bad parity is not checked here
      idle(); d_data = 1; d_wr = 1; d_mst = 1; d_irdy = 0; d_trdy = 0; d_clr = 3'b111; cyc();
      idle(); d_inj = 1; cyc();
      idle(); cyc();
      check(perr_n_o == 1 && sts_o == 0, "R3 no check on initiator write", sts_o, 0);

      // R6: target address phase with bad parity -> serr at phase+2
      idle(); d_addr = 1; d_ad = 32'hDEAD_BEEF; d_cbe = 4'h6; cyc();
      idle(); d_inj = 1; cyc();
      check(serr_n_o == 0 && sts_o[1] == 1, "R6 serr low at phase+2", serr_n_o, 0);
      idle(); cyc();
      check(serr_n_o == 1, "R6 serr single clock", serr_n_o, 1);

      // R7: set and clear in the same clock, set wins; later clear alone removes it
      idle(); d_clr = 3'b111; cyc();
      idle(); d_data = 1; d_wr = 1; d_irdy = 0; d_trdy = 0; d_ad = 32'h0F0F_0F0F; cyc();
      idle(); d_inj = 1; d_clr = 3'b001; cyc();
      check(sts_o[0] == 1, "R7 set wins over clear", sts_o, 3'b001);
      idle(); d_clr = 3'b001; cyc();
      check(sts_o[0] == 0, "R7 clear by write one", sts_o, 0);

      // R8/R9: initiator write sees reported error, halt after burst end, release on clear
      idle(); d_mst = 1; d_wr = 1; d_data = 1; d_perr = 0; cyc();
      check(sts_o[2] == 1 && halt_o == 0, "R8 report sets initiator bit", sts_o, 3'b100);
      idle(); cyc();
      check(halt_o == 0, "R9 no halt before burst end", halt_o, 0);
      idle(); d_burst = 1; cyc();
      check(halt_o == 1, "R9 halt after burst end", halt_o, 1);
      idle(); cyc();
      check(halt_o == 1, "R9 halt held", halt_o, 1);
      idle(); d_clr = 3'b100; cyc();
      check(halt_o == 0 && sts_o[2] == 0, "R9 halt released by clear", halt_o, 0);

      // R8: initiator read data mismatch sets initiator bit
      idle(); d_mst = 1; d_data = 1; d_irdy = 0; d_trdy = 0; d_ad = 32'h7777_0000; cyc();
      idle(); d_inj = 1; cyc();
      check(sts_o[2] == 1 && sts_o[0] == 1 && perr_n_o == 0, "R8 read mismatch as initiator",
            sts_o, 3'b101);
      idle(); d_clr = 3'b111; cyc();

      // random traffic checked every clock against the model
      for (int i = 0; i < 4000; i++) begin
         d_ad    = $urandom;
         d_cbe   = 4'($urandom);
         d_addr  = ($urandom % 5) == 0;
         d_data  = ($urandom % 5) < 3;
         d_wr    = 1'($urandom);
         d_mst   = 1'($urandom);
         d_irdy  = ($urandom % 10) < 3;
         d_trdy  = ($urandom % 10) < 3;
         d_perr  = ($urandom % 20) != 0;
         d_burst = ($urandom % 7) == 0;
         d_inj   = ($urandom % 8) == 0;
         d_clr   = (($urandom % 6) == 0) ? 3'($urandom) : 3'b000;
         cyc();
      end
      idle(); cyc();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule